// File: doc/BRIEF.md
# Iterative Block Decryption Round Sequencer

This block runs the control side of a 16-round iterative decryption of one 128-bit block. A request loads a ciphertext block and eight 32-bit whitening words. The block XORs the four input words with the upper four whitening words and latches the result. It then drives an external combinational round function for sixteen consecutive cycles. On each cycle it presents the current state and an 8-bit even/odd subkey index pair. The round function's result comes back on an input port and is captured in a round register.

After the sixteenth capture, the round result goes to the output whitening path instead of back to the round input. There the two halves of the block are exchanged and XORed with the lower four whitening words. The result is held as the plaintext. The round function, S-box logic, subkey generation and any chaining mode sit outside the block.

A request is accepted only while the sequencer is idle. A single-cycle completion pulse marks the plaintext as valid. The plaintext stays unchanged until the next accepted request, which clears it to zero.

Top module: `blk_dec_seq`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `ptext_o` is all zeros.
- R2: On the first round after an accepted start, `rnd_state_o` word i (word 0 = bits 127:96) equals ciphertext word i XOR whitening word K(4+i). Whitening word Kj sits at `wk_i[32*j+31:32*j]`.
- R3: On every later round, `rnd_state_o` equals the `rnd_result_i` value sampled on the previous cycle.
- R4: Round r (r = 0 to 15) presents even index 2*(15-r)+8 and odd index one greater. The first round therefore uses 38/39 and the last uses 8/9.
- R5: Exactly 16 rounds run per block. `busy_o` is high for 16 cycles after the accepting clock edge and falls together with the rise of `done_o`.
- R6: The plaintext words are K0^s2, K1^s3, K2^s0 and K3^s1. Here s is the 16th round result, with word 0 the most significant and listed first.
- R7: A start request while `busy_o` is high is ignored. The running block's input, round count and result are unchanged.
- R8: `ptext_o` keeps its value until the next accepted start. It reads zero from the cycle after that start until the new result.
- R9: `done_o` is high for exactly one cycle per block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to decrypt `ctext_i` with `wk_i` |
| ctext_i | input | 128 | Ciphertext block, word 0 in bits 127:96 |
| wk_i | input | 256 | Whitening words K0..K7, Kj in bits 32*j+31:32*j |
| rnd_state_o | output | 128 | State presented to the external round function |
| rnd_even_o | output | 8 | Even subkey index for the current round |
| rnd_odd_o | output | 8 | Odd subkey index for the current round |
| rnd_result_i | input | 128 | Combinational result of the external round function |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle pulse: plaintext valid |
| ptext_o | output | 128 | Plaintext block |

## Verification
The bench stands in for the external round function with a rotate-and-inject mock, so any error in the index order or round count changes the result. An all-zero block with zero keys isolates the index injection and round count, since nothing else contributes. A block with four distinct words and zero keys exposes a wrong half swap, and a zero block with distinct keys exposes a wrong key-to-word pairing. A dense mixed pattern is then combined with a start request during a run, a hold period after completion, and a reset in the middle of a block.

// File: rtl/dec_seq_pkg.sv
package dec_seq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/dec_rst_sync.sv
module dec_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/dec_round_ctrl.sv
module dec_round_ctrl
  import dec_seq_pkg::*;
#(
  parameter int ROUNDS   = 16,
  parameter int IDX_W    = 8,
  parameter int IDX_BASE = 8,
  parameter int CNT_W    = $clog2(ROUNDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic             capture_o,
  output logic             last_o,
  output logic             first_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [IDX_W-1:0] even_o,
  output logic [IDX_W-1:0] odd_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ROUNDS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] remain;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_CNT) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
          done_d  = 1'b1;
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // descending index pair: even = 2*(ROUNDS-1-cnt) + IDX_BASE
  always_comb begin
    remain = IDX_W'(ROUNDS - 1) - IDX_W'(cnt_q);
    even_o = IDX_W'(IDX_BASE) + (remain << 1);
    odd_o  = even_o + 1'b1;
  end

  assign accept_o  = start_i && (state_q == ST_IDLE);
  assign capture_o = (state_q == ST_RUN);
  assign last_o    = capture_o && (cnt_q == LAST_CNT);
  assign first_o   = (cnt_q == '0);
  assign busy_o    = capture_o;
  assign done_o    = done_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/dec_whiten_in.sv
module dec_whiten_in #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int BLK_W  = WORD_W * WORDS
) (
  input  logic [BLK_W-1:0] blk_i,
  input  logic [BLK_W-1:0] keys_i,   // key word i at bits [i*WORD_W +: WORD_W]
  output logic [BLK_W-1:0] blk_o
);
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    // block word i counted from the most significant end
    assign blk_o[BLK_W-1-i*WORD_W -: WORD_W] =
      blk_i[BLK_W-1-i*WORD_W -: WORD_W] ^ keys_i[i*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/dec_whiten_out.sv
module dec_whiten_out #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int BLK_W  = WORD_W * WORDS
) (
  input  logic [BLK_W-1:0] blk_i,
  input  logic [BLK_W-1:0] keys_i,   // key word i at bits [i*WORD_W +: WORD_W]
  output logic [BLK_W-1:0] blk_o
);
  localparam int HALF = WORDS / 2;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam int SRC = (i + HALF) % WORDS;
    assign blk_o[BLK_W-1-i*WORD_W -: WORD_W] =
      blk_i[BLK_W-1-SRC*WORD_W -: WORD_W] ^ keys_i[i*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/dec_state_regs.sv
module dec_state_regs #(
  parameter int BLK_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BLK_W-1:0] din_i,
  input  logic             capture_i,
  input  logic             first_i,
  input  logic [BLK_W-1:0] result_i,
  output logic [BLK_W-1:0] in_q_o,
  output logic [BLK_W-1:0] state_o
);
  logic [BLK_W-1:0] in_q, in_d;
  logic [BLK_W-1:0] rnd_q, rnd_d;

  always_comb begin
    in_d  = in_q;
    rnd_d = rnd_q;
    if (load_i) begin
      in_d  = din_i;
      rnd_d = '0;               // synchronous clear at block start
    end else if (capture_i) begin
      rnd_d = result_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      rnd_q <= '0;
    end else begin
      in_q  <= in_d;
      rnd_q <= rnd_d;
    end
  end

  assign state_o = first_i ? in_q : rnd_q;
  assign in_q_o  = in_q;
endmodule

// File: rtl/blk_dec_seq.sv
module blk_dec_seq #(
  parameter int WORD_W   = 32,
  parameter int WORDS    = 4,
  parameter int ROUNDS   = 16,
  parameter int IDX_W    = 8,
  parameter int IDX_BASE = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [WORD_W*WORDS-1:0]   ctext_i,
  input  logic [2*WORD_W*WORDS-1:0] wk_i,
  output logic [WORD_W*WORDS-1:0]   rnd_state_o,
  output logic [IDX_W-1:0]      rnd_even_o,
  output logic [IDX_W-1:0]      rnd_odd_o,
  input  logic [WORD_W*WORDS-1:0]   rnd_result_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [WORD_W*WORDS-1:0]   ptext_o
);
  localparam int BLK_W = WORD_W * WORDS;
  localparam int CNT_W = $clog2(ROUNDS);

  logic             rst_sync_n;
  logic             accept, capture, last, first;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] whitened, in_q, plain_next;
  logic [BLK_W-1:0] okey_q, okey_d;
  logic [BLK_W-1:0] ptext_q, ptext_d;

  dec_rst_sync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  dec_round_ctrl #(
    .ROUNDS(ROUNDS), .IDX_W(IDX_W), .IDX_BASE(IDX_BASE), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .start_i  (start_i),
    .accept_o (accept),
    .capture_o(capture),
    .last_o   (last),
    .first_o  (first),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .cnt_o    (cnt),
    .even_o   (rnd_even_o),
    .odd_o    (rnd_odd_o)
  );

  dec_whiten_in #(.WORD_W(WORD_W), .WORDS(WORDS)) u_win (
    .blk_i (ctext_i),
    .keys_i(wk_i[2*BLK_W-1:BLK_W]),
    .blk_o (whitened)
  );

  dec_state_regs #(.BLK_W(BLK_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .load_i   (accept),
    .din_i    (whitened),
    .capture_i(capture),
    .first_i  (first),
    .result_i (rnd_result_i),
    .in_q_o   (in_q),
    .state_o  (rnd_state_o)
  );

  dec_whiten_out #(.WORD_W(WORD_W), .WORDS(WORDS)) u_wout (
    .blk_i (rnd_result_i),
    .keys_i(okey_q),
    .blk_o (plain_next)
  );

  // output key words and plaintext: next-state
  always_comb begin
    okey_d  = okey_q;
    ptext_d = ptext_q;
    if (accept) begin
      okey_d  = wk_i[BLK_W-1:0];
      ptext_d = '0;
    end else if (last) begin
      ptext_d = plain_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      okey_q  <= '0;
      ptext_q <= '0;
    end else begin
      okey_q  <= okey_d;
      ptext_q <= ptext_d;
    end
  end

  assign ptext_o = ptext_q;
endmodule

// File: rtl/dec_seq_checker.sv
module dec_seq_checker #(
  parameter int BLK_W    = 128,
  parameter int IDX_W    = 8,
  parameter int ROUNDS   = 16,
  parameter int IDX_BASE = 8,
  parameter int CNT_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             done_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [BLK_W-1:0] state_i,
  input logic [BLK_W-1:0] result_i,
  input logic [BLK_W-1:0] ptext_i,
  input logic [BLK_W-1:0] in_q_i,
  input logic [IDX_W-1:0] even_i,
  input logic [IDX_W-1:0] odd_i
);
  localparam logic [IDX_W-1:0] FIRST_EVEN = IDX_W'(2 * (ROUNDS - 1) + IDX_BASE);
  localparam logic [IDX_W-1:0] LAST_EVEN  = IDX_W'(IDX_BASE);
  localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(ROUNDS - 1);

  assert_idx_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (odd_i == even_i + 1'b1));

  assert_first_idx_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !$past(busy_i)) |-> (even_i == FIRST_EVEN));

  assert_idx_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> (even_i == $past(even_i) - 2'd2));

  assert_last_idx_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cnt_i == LAST_CNT) |-> (even_i == LAST_EVEN));

  assert_feedback_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> (state_i == $past(result_i)));

  assert_round_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cnt_i == LAST_CNT) |=> (done_i && !busy_i));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(in_q_i));

  assert_ptext_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !done_i) |-> $stable(ptext_i));
endmodule

bind blk_dec_seq dec_seq_checker #(
  .BLK_W(BLK_W), .IDX_W(IDX_W), .ROUNDS(ROUNDS), .IDX_BASE(IDX_BASE), .CNT_W(CNT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_sync_n),
  .busy_i  (busy_o),
  .done_i  (done_o),
  .cnt_i   (cnt),
  .state_i (rnd_state_o),
  .result_i(rnd_result_i),
  .ptext_i (ptext_o),
  .in_q_i  (in_q),
  .even_i  (rnd_even_o),
  .odd_i   (rnd_odd_o)
);

// File: tb/blk_dec_seq_test.sv
module blk_dec_seq_test;
  logic         clk;
  logic         rst_n;
  logic         start;
  logic [127:0] ctext;
  logic [255:0] wk;
  logic [127:0] rnd_state, rnd_result, ptext;
  logic [7:0]   even, odd;
  logic         busy, done;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  blk_dec_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ctext_i(ctext), .wk_i(wk),
    .rnd_state_o(rnd_state), .rnd_even_o(even), .rnd_odd_o(odd),
    .rnd_result_i(rnd_result), .busy_o(busy), .done_o(done), .ptext_o(ptext)
  );

  // mock round function: rotate left by one, inject the index pair
  function automatic logic [127:0] mock(input logic [127:0] s, input logic [7:0] e, input logic [7:0] o);
    return {s[126:0], s[127]} ^ {e, 104'h0, e, o};
  endfunction

  assign rnd_result = mock(rnd_state, even, odd);

  function automatic logic [31:0] kw(input logic [255:0] k, input int j);
    return k[32*j +: 32];
  endfunction

  function automatic logic [127:0] whiten_ref(input logic [127:0] c, input logic [255:0] k);
    return c ^ {kw(k,4), kw(k,5), kw(k,6), kw(k,7)};
  endfunction

  function automatic logic [127:0] plain_ref(input logic [127:0] c, input logic [255:0] k);
    logic [127:0] s;
    s = whiten_ref(c, k);
    for (int r = 0; r < 16; r++) begin
      s = mock(s, 8'(2*(15-r)+8), 8'(2*(15-r)+9));
    end
    return {kw(k,0) ^ s[63:32], kw(k,1) ^ s[31:0], kw(k,2) ^ s[127:96], kw(k,3) ^ s[95:64]};
  endfunction

  function automatic logic [255:0] mk_keys(input logic [31:0] seed);
    logic [255:0] k;
    for (int j = 0; j < 8; j++) k[32*j +: 32] = seed + 32'(j) * 32'h0103_0507;
    return k;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stimulus vectors: ciphertext, key seed, key mode (0 = all-zero keys)
  localparam logic [127:0] CT_TAB [4] = '{
    128'h0,
    128'h11111111_22222222_33333333_44444444,
    128'h0,
    128'hFFFFFFFF_A5A5A5A5_0F1E2D3C_DEADBEEF
  };
  localparam logic [31:0] SEED_TAB [4] = '{32'h0, 32'h0, 32'h1000_2000, 32'hC0FF_EE01};
  localparam bit          KMODE_TAB [4] = '{1'b0, 1'b0, 1'b1, 1'b1};

  always #5 clk = ~clk;

  // run one block; poke >= 0 raises a start with another block during that round
  task automatic run_block(input logic [127:0] c, input logic [255:0] k, input int poke);
    logic [127:0] s_exp;
    logic [127:0] p_exp;
    p_exp = plain_ref(c, k);
    @(negedge clk);
    start = 1'b1; ctext = c; wk = k;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R5 busy after accept", 128'(busy), 128'h1);
    chk(ptext === 128'h0, "R8 ptext cleared on accept", ptext, 128'h0);
    s_exp = whiten_ref(c, k);
    for (int r = 0; r < 16; r++) begin
      chk(rnd_state === s_exp, (r == 0) ? "R2 whitened first state" : "R3 fed-back state", rnd_state, s_exp);
      chk({even, odd} === {8'(2*(15-r)+8), 8'(2*(15-r)+9)}, "R4 index pair",
          128'({even, odd}), 128'({8'(2*(15-r)+8), 8'(2*(15-r)+9)}));
      if (r < 15) chk(busy === 1'b1 && done === 1'b0, "R5 still busy", 128'({busy, done}), 128'h2);
      s_exp = mock(s_exp, 8'(2*(15-r)+8), 8'(2*(15-r)+9));
      if (r == poke) begin
        start = 1'b1; ctext = ~c; wk = ~k;
      end else if (r == poke + 1) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, "R5 done after 16 rounds", 128'({busy, done}), 128'h1);
    chk(ptext === p_exp, "R6 swapped output whitening", ptext, p_exp);
    @(negedge clk);
    chk(done === 1'b0, "R9 done one cycle", 128'(done), 128'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    clk = 1'b0; rst_n = 1'b0; start = 1'b0; ctext = '0; wk = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset flags", 128'({busy, done}), 128'h0);
    chk(ptext === 128'h0, "R1 reset ptext", ptext, 128'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && ptext === 128'h0, "R1 idle after release", ptext, 128'h0);

    // vector table walk
    for (int v = 0; v < 4; v++) begin
      run_block(CT_TAB[v], KMODE_TAB[v] ? mk_keys(SEED_TAB[v]) : 256'h0, -1);
    end

    // R8: hold after completion
    held = ptext;
    repeat (5) @(negedge clk);
    chk(ptext === held && done === 1'b0, "R8 ptext holds while idle", ptext, held);

    // R7: start during a run is ignored
    run_block(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, mk_keys(32'h5A5A_0001), 5);
    run_block(128'h8000_0000_0000_0000_0000_0000_0000_0001, mk_keys(32'h7777_0000), 14);

    // R1: reset in the middle of a block
    @(negedge clk);
    start = 1'b1; ctext = 128'hABCD; wk = mk_keys(32'h3);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(busy === 1'b0 && done === 1'b0, "R1 async reset mid-block", 128'({busy, done}), 128'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ptext === 128'h0 && busy === 1'b0, "R1 cleared after mid-block reset", ptext, 128'h0);

    run_block(CT_TAB[3], mk_keys(32'h0BAD_F00D), -1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule